// File: doc/BRIEF.md
# UART Receiver with Character Queue and Line Status

This block is the receive half of an asynchronous serial port that samples its line at sixteen times the bit rate. It finds start bits, assembles characters of five to eight data bits (least significant bit first) with an optional parity bit and one stop bit. It stores each character together with two error tags, one for a parity mismatch and one for a bad stop bit. A host reads received characters and a status word through a two-address read port.

There are two storage modes. In queue mode a 16-entry first-in first-out buffer holds characters, and each character's error tags stay with it. The tags appear in the status word only while that character is at the head of the queue. In single-register mode one holding register is used. A new character replaces an unread one, and its error flags stay set until the status word is read. In both modes an overrun flag records lost data, and a status read clears it. The mode and line format are expected to change only while the line is idle and the storage is empty.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the status word reads 0x00, and a read at the data address returns 0x00.
- R2: A start is detected on the first tick with the line low, and the line is sampled again 8 ticks later. If it is high then, the event is discarded and nothing is stored. Later bits are sampled every 16 ticks after that point.
- R3: `wordLen` selects the data width as 5 + `wordLen` bits (00 = 5 bits, 11 = 8 bits). Bits arrive least significant first. A read at the data address returns the character right-aligned, with the unused upper bits zero.
- R4: When `parityEn` is 1, one parity bit follows the data. With `evenParity` = 1 the data bits plus the parity bit must hold an even number of ones, and with `evenParity` = 0 an odd number. A mismatch sets status bit 2.
- R5: A stop bit sampled low sets status bit 3.
- R6: Status bit 0 is 1 whenever at least one unread character is stored. Each read at the data address (`rdAddr` = 0) removes one character, and bit 0 returns to 0 once the last one is read.
- R7: In queue mode (`fifoEn` = 1), up to 16 characters are held and read back in arrival order.
- R8: In queue mode, a character that completes while 16 are held is discarded, status bit 1 (overrun) is set at once, and the stored characters are unchanged.
- R9: In single-register mode (`fifoEn` = 0), a character that completes while the previous one is unread replaces it and sets status bit 1.
- R10: A status read (`rdAddr` = 1) clears the overrun flag. In single-register mode it also clears the parity and framing flags, which otherwise persist after the character itself has been read.
- R11: In queue mode, status bits 2 and 3 show only the tags of the head character. A status read clears the head's tags and leaves the tags of the entries behind it intact.
- R12: The status word is {4'b0, framing, parity, overrun, data ready}. A data read with nothing stored returns 0x00 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| serialIn | input | 1 | Serial line, idle high |
| fifoEn | input | 1 | 1 = queue mode, 0 = single-register mode |
| wordLen | input | 2 | Data bits minus five |
| parityEn | input | 1 | Parity bit present |
| evenParity | input | 1 | 1 = even parity, 0 = odd |
| rdEn | input | 1 | Read strobe; side effects take place at the clock edge |
| rdAddr | input | 1 | 0 = data, 1 = status |
| rdData | output | 8 | Read value for the addressed location, valid in the cycle `rdEn` is high |

## Verification
The hardest state to reach is a full queue that holds tagged characters away from the head while one more character completes on the line. The stimulus sends sixteen characters, with a parity error and a framing error placed in the middle, then sends a seventeenth. The status read that follows must show overrun without either error tag. Draining the queue through a scoreboard then shows each tag appear only when its character reaches the head, and shows that one status read removes it. A bad stop bit is held low past its midpoint so that the receiver briefly sees a false start, which also exercises start-bit rejection.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

  localparam int MIN_BITS = 5;
  localparam int LEN_W    = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rx_state_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic charDone;
    logic peTag;
    logic feTag;
    logic store;
    logic overwrite;
    logic pop;
    logic clrHeadTags;
  } rx_strobe_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
`timescale 1ns/1ps
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick16,
  input  logic             serialIn,
  input  logic             fifoEn,
  input  logic [LEN_W-1:0] wordLen,
  input  logic             parityEn,
  input  logic             evenParity,
  input  logic             rdEn,
  input  logic             rdAddr,
  input  logic             fifoFull,
  input  logic             fifoEmpty,
  input  logic             headPe,
  input  logic             headFe,
  output rx_strobe_t       strobe,
  output logic [7:0]       statusWord
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);

  rx_state_e        state;
  logic [CNT_W-1:0] tickCnt;
  logic [2:0]       bitIdx;
  logic             parAcc;
  logic             parErr;
  logic             oeFlag;
  logic             peSticky;
  logic             feSticky;

  logic lastBit;
  logic sampleNow;
  logic statusRd;
  logic canStore;
  logic overrun;

  assign lastBit   = (bitIdx == (3'(wordLen) + 3'(MIN_BITS - 1)));
  assign sampleNow = tick16 && (tickCnt == LAST_CNT);
  assign statusRd  = rdEn && rdAddr;

  // bit framing state machine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      parAcc  <= 1'b0;
      parErr  <= 1'b0;
    end else if (tick16) begin
      case (state)
        ST_IDLE: begin
          if (!serialIn) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (tickCnt == MID_CNT) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            parAcc  <= 1'b0;
            parErr  <= 1'b0;
            state   <= serialIn ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: begin
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            case (state)
              ST_DATA: begin
                parAcc <= parAcc ^ serialIn;
                if (lastBit) state <= parityEn ? ST_PARITY : ST_STOP;
                else         bitIdx <= bitIdx + 1'b1;
              end
              ST_PARITY: begin
                parErr <= parAcc ^ serialIn ^ ~evenParity;
                state  <= ST_STOP;
              end
              default: state <= ST_IDLE;
            endcase
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
      endcase
    end
  end

  // strobe generation
  always_comb begin
    strobe             = '0;
    strobe.shiftEn     = (state == ST_DATA) && sampleNow;
    strobe.shiftBit    = serialIn;
    strobe.charDone    = (state == ST_STOP) && sampleNow;
    strobe.feTag       = !serialIn;
    strobe.peTag       = parityEn && parErr;
    strobe.pop         = rdEn && !rdAddr && !fifoEmpty;
    strobe.clrHeadTags = statusRd && fifoEn;
    strobe.store       = strobe.charDone && canStore;
    strobe.overwrite   = strobe.charDone && !canStore && !fifoEn;
  end

  assign canStore = !fifoFull || strobe.pop;
  assign overrun  = strobe.charDone && !canStore;

  // line status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeFlag   <= 1'b0;
      peSticky <= 1'b0;
      feSticky <= 1'b0;
    end else begin
      if (overrun)       oeFlag <= 1'b1;
      else if (statusRd) oeFlag <= 1'b0;

      if (strobe.charDone && !fifoEn && strobe.peTag) peSticky <= 1'b1;
      else if (statusRd)                                peSticky <= 1'b0;

      if (strobe.charDone && !fifoEn && strobe.feTag) feSticky <= 1'b1;
      else if (statusRd)                                feSticky <= 1'b0;
    end
  end

  assign statusWord = {4'b0000,
                       fifoEn ? headFe : feSticky,
                       fifoEn ? headPe : peSticky,
                       oeFlag,
                       !fifoEmpty};

  // R2
  start_glitch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && tick16 && tickCnt == MID_CNT && serialIn) |=> (state == ST_IDLE));

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.charDone && fifoFull && !strobe.pop) |=> oeFlag);

  // R10
  oe_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !strobe.charDone) |=> !oeFlag);

endmodule

// File: rtl/uart_rx_datapath.sv
`timescale 1ns/1ps
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEn,
  input  logic [LEN_W-1:0]  wordLen,
  input  rx_strobe_t        strobe,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              headPe,
  output logic              headFe,
  output logic [DATA_W-1:0] headData
);

  localparam int PTR_W    = $clog2(DEPTH);
  localparam int CNT_W    = PTR_W + 1;
  localparam int LEN_SPAN = DATA_W - MIN_BITS;
  localparam int SH_W     = $clog2(DATA_W);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] alignedData;
  logic [SH_W-1:0]   shiftAmt;

  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [DEPTH-1:0]  peVec;
  logic [DEPTH-1:0]  feVec;
  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W-1:0]  wrPtr;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  capacity;
  logic [PTR_W-1:0]  writeIdx;
  logic              writeEn;

  // serial-to-parallel, LSB first, aligned at the end of the character
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {strobe.shiftBit, shiftReg[DATA_W-1:1]};
  end

  assign shiftAmt    = SH_W'(LEN_SPAN) - SH_W'(wordLen);
  assign alignedData = shiftReg >> shiftAmt;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign capacity  = fifoEn ? CNT_W'(DEPTH) : CNT_W'(1);
  assign fifoFull  = (count >= capacity);
  assign fifoEmpty = (count == '0);
  assign writeEn   = strobe.store || strobe.overwrite;
  assign writeIdx  = strobe.overwrite ? rdPtr : wrPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.store) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)   rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(strobe.store) - CNT_W'(strobe.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (writeEn) dataMem[writeIdx] <= alignedData;
  end

  // per-entry error tags
  for (genvar e = 0; e < DEPTH; e++) begin : g_tag
    logic peQ;
    logic feQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        peQ <= 1'b0;
        feQ <= 1'b0;
      end else if (writeEn && writeIdx == PTR_W'(e)) begin
        peQ <= strobe.peTag;
        feQ <= strobe.feTag;
      end else if (strobe.clrHeadTags && !fifoEmpty && rdPtr == PTR_W'(e)) begin
        peQ <= 1'b0;
        feQ <= 1'b0;
      end
    end
    assign peVec[e] = peQ;
    assign feVec[e] = feQ;
  end

  assign headData = dataMem[rdPtr];
  assign headPe   = !fifoEmpty && peVec[rdPtr];
  assign headFe   = !fifoEmpty && feVec[rdPtr];

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R8
  drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && strobe.charDone && fifoFull && !strobe.pop) |=> $stable(count));

  // R6
  store_not_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.store |=> !fifoEmpty);

endmodule

// File: rtl/uart_rx_status.sv
`timescale 1ns/1ps
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       serialIn,
  input  logic       fifoEn,
  input  logic [1:0] wordLen,
  input  logic       parityEn,
  input  logic       evenParity,
  input  logic       rdEn,
  input  logic       rdAddr,
  output logic [7:0] rdData
);

  rx_strobe_t strobe;
  logic       fifoFull;
  logic       fifoEmpty;
  logic       headPe;
  logic       headFe;
  logic [7:0] headData;
  logic [7:0] statusWord;

  uart_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick16     (tick16),
    .serialIn   (serialIn),
    .fifoEn     (fifoEn),
    .wordLen    (wordLen),
    .parityEn   (parityEn),
    .evenParity (evenParity),
    .rdEn       (rdEn),
    .rdAddr     (rdAddr),
    .fifoFull   (fifoFull),
    .fifoEmpty  (fifoEmpty),
    .headPe     (headPe),
    .headFe     (headFe),
    .strobe     (strobe),
    .statusWord (statusWord)
  );

  uart_rx_datapath #(.DEPTH(DEPTH), .DATA_W(8)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .fifoEn    (fifoEn),
    .wordLen   (wordLen),
    .strobe    (strobe),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .headPe    (headPe),
    .headFe    (headFe),
    .headData  (headData)
  );

  assign rdData = rdAddr ? statusWord : (fifoEmpty ? 8'h00 : headData);

endmodule

// File: tb/tb_uart_rx_status.sv
`timescale 1ns/1ps
module tb_uart_rx_status;

  typedef struct {
    logic [7:0] d;
    bit         pe;
    bit         fe;
  } exp_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       serialIn = 1'b1;
  logic       fifoEn = 1'b0;
  logic [1:0] wordLen = 2'b11;
  logic       parityEn = 1'b0;
  logic       evenParity = 1'b1;
  logic       rdEn = 1'b0;
  logic       rdAddr = 1'b0;
  logic [7:0] rdData;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [1:0] divCnt = '0;
  exp_t expQ[$];

  uart_rx_status dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .serialIn(serialIn),
    .fifoEn(fifoEn), .wordLen(wordLen), .parityEn(parityEn),
    .evenParity(evenParity), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  always #4 clk = ~clk;

  // tick every fourth cycle, changed away from the rising edge
  always @(negedge clk) begin
    divCnt <= divCnt + 2'd1;
    tick16 <= (divCnt == 2'd3);
  end

  task automatic checkVal(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, expv);
    end
  endtask

  task automatic waitTick();
    @(posedge clk);
    while (!tick16) @(posedge clk);
    #1;
  endtask

  task automatic sendBit(input logic b, input int n);
    serialIn = b;
    repeat (n) waitTick();
  endtask

  task automatic sendChar(input logic [7:0] d, input bit badPar, input bit badStop);
    int   nBits;
    logic ones;
    logic pBit;
    nBits = 5 + int'(wordLen);
    ones = 1'b0;
    for (int i = 0; i < nBits; i++) ones ^= d[i];
    pBit = evenParity ? ones : ~ones;
    if (badPar) pBit = ~pBit;
    sendBit(1'b0, 16);
    for (int i = 0; i < nBits; i++) sendBit(d[i], 16);
    if (parityEn) sendBit(pBit, 16);
    if (badStop) begin
      sendBit(1'b0, 12);
      sendBit(1'b1, 4);
    end else begin
      sendBit(1'b1, 16);
    end
    sendBit(1'b1, 8);
  endtask

  // driver: sends a character and records what the scoreboard should see
  task automatic driveChar(input logic [7:0] d, input bit badPar, input bit badStop);
    exp_t e;
    e.d  = d;
    e.pe = parityEn && badPar;
    e.fe = badStop;
    sendChar(d, badPar, badStop);
    if (expQ.size() < 16) expQ.push_back(e);
  endtask

  task automatic busRead(input logic addr, output logic [7:0] val);
    @(negedge clk);
    rdAddr = addr;
    rdEn   = 1'b1;
    #1 val = rdData;
    @(posedge clk);
    #1 rdEn = 1'b0;
  endtask

  // monitor: drains the queue and compares against the scoreboard
  task automatic drainCheck();
    logic [7:0] v;
    exp_t e;
    while (expQ.size() > 0) begin
      e = expQ.pop_front();
      busRead(1'b1, v);
      checkVal("R11 head tags in status", v, {4'b0, e.fe, e.pe, 1'b0, 1'b1});
      if (e.pe || e.fe) begin
        busRead(1'b1, v);
        checkVal("R11 head tags cleared by status read", v, 8'h01);
      end
      busRead(1'b0, v);
      checkVal("R7 queue order", v, e.d);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (4) waitTick();

    // R1 reset state
    busRead(1'b1, v); checkVal("R1 status after reset", v, 8'h00);
    busRead(1'b0, v); checkVal("R1 data after reset", v, 8'h00);

    // R2 short low pulse is rejected
    sendBit(1'b0, 4);
    sendBit(1'b1, 32);
    busRead(1'b1, v); checkVal("R2 glitch stores nothing", v, 8'h00);

    // R3 8 data bits, no parity
    sendChar(8'hA5, 0, 0);
    busRead(1'b1, v); checkVal("R6 data ready set", v, 8'h01);
    busRead(1'b0, v); checkVal("R3 8-bit data", v, 8'hA5);
    busRead(1'b1, v); checkVal("R6 data ready cleared", v, 8'h00);
    busRead(1'b0, v); checkVal("R12 empty data read", v, 8'h00);

    // R3 5 data bits with odd parity
    wordLen = 2'b00; parityEn = 1'b1; evenParity = 1'b0;
    sendChar(8'h15, 0, 0);
    busRead(1'b1, v); checkVal("R4 odd parity correct", v, 8'h01);
    busRead(1'b0, v); checkVal("R3 5-bit data", v, 8'h15);

    // R4 bad parity, R10 sticky flag in single-register mode
    sendChar(8'h0B, 1, 0);
    busRead(1'b0, v); checkVal("R3 5-bit data with bad parity", v, 8'h0B);
    busRead(1'b1, v); checkVal("R10 parity flag survives data read", v, 8'h04);
    busRead(1'b1, v); checkVal("R10 status read clears parity", v, 8'h00);

    // R4 7 bits even parity, bad parity
    wordLen = 2'b10; evenParity = 1'b1;
    sendChar(8'h63, 1, 0);
    busRead(1'b1, v); checkVal("R4 even parity mismatch", v, 8'h05);
    busRead(1'b0, v); checkVal("R3 7-bit data", v, 8'h63);

    // R5 framing error
    wordLen = 2'b11; parityEn = 1'b0;
    sendChar(8'h3C, 0, 1);
    busRead(1'b1, v); checkVal("R5 framing flag", v, 8'h09);
    busRead(1'b0, v); checkVal("R5 data with bad stop", v, 8'h3C);
    busRead(1'b1, v); checkVal("R10 framing cleared", v, 8'h00);

    // R9 overwrite in single-register mode
    sendChar(8'h11, 0, 0);
    sendChar(8'h22, 0, 0);
    busRead(1'b1, v); checkVal("R9 overrun flagged", v, 8'h03);
    busRead(1'b0, v); checkVal("R9 newest character kept", v, 8'h22);
    busRead(1'b1, v); checkVal("R10 overrun cleared", v, 8'h00);

    // R7 R8 R11 queue mode: fill, overflow, drain
    fifoEn = 1'b1; parityEn = 1'b1; evenParity = 1'b1;
    for (int i = 0; i < 16; i++)
      driveChar(8'h30 + 8'(i), (i == 3), (i == 7));
    busRead(1'b1, v); checkVal("R11 no tags while clean head", v, 8'h01);
    driveChar(8'hEE, 0, 0);
    busRead(1'b1, v); checkVal("R8 overrun when full", v, 8'h03);
    drainCheck();
    busRead(1'b1, v); checkVal("R6 empty after drain", v, 8'h00);
    busRead(1'b0, v); checkVal("R12 empty data read in queue mode", v, 8'h00);

    // R2 glitch then a valid character in queue mode
    sendBit(1'b0, 6);
    sendBit(1'b1, 20);
    driveChar(8'h5A, 0, 0);
    busRead(1'b1, v); checkVal("R2 single stored after glitch", v, 8'h01);
    drainCheck();

    finished = 1;
    summary();
    $finish;
  end

endmodule